// File: doc/BRIEF.md
# Receive Task Sequencer with Status Flags

This block runs the receive side of a four-level symbol modem under the control of a host. The host writes a task code. The sequencer then counts the incoming two-bit symbols that belong to that task. For the two block tasks and the station identity task, it removes the embedded status symbols and passes every other symbol to an external de-interleaver, FEC decoder and CRC checker. That decoder returns decoded bytes, plus a checksum-valid flag, on a valid/ready handshake. The sequencer writes those bytes into the host byte buffer in the order they arrive.

In raw mode no decoding takes place. The sequencer packs four symbols directly into one byte. It owns five status flags: buffer-ready, interrupt, status-symbol-ready, the value of the last status symbol, and checksum error. It sets them as status symbols arrive and as tasks finish. Host reads of the status word or the buffer clear them.

A block is 69 symbols long. The status symbols sit at parameterised positions, by default 22, 45 and 68, counted from 0. The last of them closes the block. Its flag update is held back until the decoder has delivered every byte of the block, so that status-symbol-ready and buffer-ready rise together.

Top module: `rx_task_seq`

## Requirements
- R1: Task code 0 (header) and code 1 (intermediate/last) consume 69 symbols each. Symbols at indices 22, 45 and 68 are status symbols. The other 66 are forwarded on `pay_valid`/`pay_data` in arrival order, and no status symbol is forwarded.
- R2: Header and block tasks accept exactly 12 decoded bytes and write them to buffer addresses 0 to 11 in arrival order. `dec_ready` is low once the twelfth byte has been accepted.
- R3: A status symbol other than a task's last sets `st_srdy` and loads `st_sval` with the symbol value. It sets `st_irq` only while `sym_irq_en` is 1.
- R4: A decoded task completes in the cycle in which both its final status symbol has been received and all its bytes have been accepted. In that cycle `st_bfree`, `st_srdy` and `st_irq` are all set, `st_sval` takes the final symbol's value and `busy` falls. Before that cycle, the final symbol changes no flag.
- R5: At completion of a header, block or station identity task, `st_crcerr` is loaded with the inverse of the `dec_crc_ok` that arrived with the task's last byte.
- R6: Task code 2 (raw) reads 4 symbols. The first symbol lands in bits 7:6 and the fourth in bits 1:0 of one byte, which is written to address 0. It sets `st_bfree` and `st_irq`, leaves `st_srdy`, `st_sval` and `st_crcerr` unchanged, and forwards no payload.
- R7: Task code 3 (station identity) forwards 23 payload symbols, treats index 23 as its final status symbol, and writes 3 decoded bytes to addresses 0 to 2.
- R8: A command write while a task is running abandons it. Symbol and byte counts restart, and the new task treats the next symbol as its index 0.
- R9: `stat_rd` clears `st_irq` and `st_srdy`, and `buf_rd` clears `st_bfree`. A set in the same cycle takes priority.
- R10: While no task is running, symbols and decoder bytes are ignored: no payload is forwarded, `dec_ready` is low and no flag changes.
- R11: After reset all flags are 0, `st_sval` is 0 and `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_wr | input | 1 | Task command write strobe |
| cmd_code | input | 2 | Task code: 0 header, 1 block, 2 raw, 3 station identity |
| sym_irq_en | input | 1 | Interrupt on each non-final status symbol |
| sym_valid | input | 1 | Received symbol strobe |
| sym_data | input | 2 | Received symbol value |
| pay_valid | output | 1 | Payload symbol to the decoder |
| pay_data | output | 2 | Payload symbol value |
| dec_valid | input | 1 | Decoded byte offered |
| dec_byte | input | 8 | Decoded byte |
| dec_crc_ok | input | 1 | Checksum valid, qualified by the task's last byte |
| dec_ready | output | 1 | Sequencer accepts a decoded byte |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | 4 | Buffer write address |
| buf_wdata | output | 8 | Buffer write data |
| stat_rd | input | 1 | Host read of the status word |
| buf_rd | input | 1 | Host read of the buffer |
| st_bfree | output | 1 | Buffer holds a result for the host |
| st_irq | output | 1 | Interrupt request |
| st_srdy | output | 1 | Status symbol received |
| st_sval | output | 2 | Value of the latest status symbol |
| st_crcerr | output | 1 | Checksum error of the last decoded task |
| busy | output | 1 | Task in progress |

## Verification
The bench sweeps all 256 raw byte values, so a design that packs symbols in the wrong order or by the wrong shift fails on asymmetric patterns. It also runs blocks whose status symbols take every value, with the interrupt enable both on and off. A design that forwards a status symbol or drops a payload symbol shows a wrong payload count or sequence. A design that raises the interrupt regardless of the enable is caught after the first mid-block status symbol. A design that flags completion on the final symbol while decoder bytes are still outstanding shows buffer-ready too early. Aborting one task with another shows whether the symbol counter really restarts, because a stale count would report the status symbol at the wrong index.

// File: rtl/rx_task_pkg.sv
package rx_task_pkg;
   typedef enum logic [1:0] {
      TK_HDR = 2'd0,
      TK_BLK = 2'd1,
      TK_RAW = 2'd2,
      TK_SID = 2'd3
   } task_e;

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/rx_sym_track.sv
module rx_sym_track
   import rx_task_pkg::*;
#(
   parameter int unsigned IDX_W    = 7,
   parameter int unsigned BLK_SYMS = 69,
   parameter int unsigned S_IDX0   = 22,
   parameter int unsigned S_IDX1   = 45,
   parameter int unsigned S_IDX2   = 68,
   parameter int unsigned SID_SYMS = 24,
   parameter int unsigned RAW_SYMS = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             advance,
   input  task_e            kind,
   output logic [IDX_W-1:0] idx,
   output logic             is_s,
   output logic             is_final
);
   localparam int unsigned N_S = 3;
   localparam int unsigned S_POS [N_S] = '{S_IDX0, S_IDX1, S_IDX2};

   logic [N_S-1:0]   hit;
   logic [IDX_W-1:0] last_idx;
   logic             blk_kind;

   for (genvar g = 0; g < N_S; g++) begin : g_spos
      if (S_POS[g] >= BLK_SYMS) begin : g_bad
         $error("status symbol position outside the block");
      end
      assign hit[g] = (idx == IDX_W'(S_POS[g]));
   end

   assign blk_kind = (kind == TK_HDR) || (kind == TK_BLK);

   always_comb begin
      unique case (kind)
         TK_HDR, TK_BLK: last_idx = IDX_W'(BLK_SYMS - 1);
         TK_RAW:         last_idx = IDX_W'(RAW_SYMS - 1);
         default:        last_idx = IDX_W'(SID_SYMS - 1);
      endcase
   end

   assign is_final = (idx == last_idx);
   assign is_s     = blk_kind ? (|hit) : ((kind == TK_SID) && is_final);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          idx <= '0;
      else if (restart)    idx <= '0;
      else if (advance)    idx <= is_final ? '0 : idx + 1'b1;
   end

   AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) idx <= last_idx); // R1
endmodule

// File: rtl/rx_raw_pack.sv
module rx_raw_pack #(
   parameter int unsigned SYM_W     = 2,
   parameter int unsigned BYTE_W    = 8,
   parameter bit          MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              shift_en,
   input  logic [SYM_W-1:0]  sym,
   output logic [BYTE_W-1:0] byte_next
);
   localparam int unsigned PRE_W = BYTE_W - SYM_W;

   logic [PRE_W-1:0] sr;

   if (MSB_FIRST) begin : g_msb
      assign byte_next = {sr, sym};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sr <= '0;
         else if (clear)    sr <= '0;
         else if (shift_en) sr <= byte_next[PRE_W-1:0];
      end
   end else begin : g_lsb
      assign byte_next = {sym, sr};
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        sr <= '0;
         else if (clear)    sr <= '0;
         else if (shift_en) sr <= byte_next[BYTE_W-1:SYM_W];
      end
   end
endmodule

// File: rtl/rx_byte_collect.sv
module rx_byte_collect #(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned CNT_W  = 4,
   parameter int unsigned AW     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              active,
   input  logic [CNT_W-1:0]  expected,
   input  logic              dec_valid,
   input  logic [BYTE_W-1:0] dec_byte,
   input  logic              dec_crc_ok,
   output logic              dec_ready,
   output logic              accept,
   output logic              last_now,
   output logic              done,
   output logic              crc_ok_eff,
   output logic [AW-1:0]     waddr,
   output logic [BYTE_W-1:0] wdata
);
   logic [CNT_W-1:0] cnt;
   logic             crc_q;

   assign dec_ready  = active && (cnt < expected);
   assign accept     = dec_valid && dec_ready;
   assign last_now   = accept && (cnt == expected - 1'b1);
   assign done       = (cnt == expected);
   assign crc_ok_eff = last_now ? dec_crc_ok : crc_q;
   assign waddr      = cnt[AW-1:0];
   assign wdata      = dec_byte;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         crc_q <= 1'b0;
      end else if (clear) begin
         cnt   <= '0;
         crc_q <= 1'b0;
      end else if (accept) begin
         cnt <= cnt + 1'b1;
         if (last_now) crc_q <= dec_crc_ok;
      end
   end

   AST_BYTE_CAP: assert property (@(posedge clk) disable iff (!rst_n) cnt <= expected); // R2
endmodule

// File: rtl/rx_status_regs.sv
module rx_status_regs #(
   parameter int unsigned SYM_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set_srdy,
   input  logic             set_irq,
   input  logic             set_bfree,
   input  logic             ld_sval,
   input  logic [SYM_W-1:0] sval_in,
   input  logic             ld_crc,
   input  logic             crcerr_in,
   input  logic             stat_rd,
   input  logic             buf_rd,
   output logic             st_bfree,
   output logic             st_irq,
   output logic             st_srdy,
   output logic [SYM_W-1:0] st_sval,
   output logic             st_crcerr
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_bfree  <= 1'b0;
         st_irq    <= 1'b0;
         st_srdy   <= 1'b0;
         st_sval   <= '0;
         st_crcerr <= 1'b0;
      end else begin
         if (set_bfree)    st_bfree <= 1'b1;
         else if (buf_rd)  st_bfree <= 1'b0;
         if (set_irq)      st_irq <= 1'b1;
         else if (stat_rd) st_irq <= 1'b0;
         if (set_srdy)     st_srdy <= 1'b1;
         else if (stat_rd) st_srdy <= 1'b0;
         if (ld_sval)      st_sval <= sval_in;
         if (ld_crc)       st_crcerr <= crcerr_in;
      end
   end

   AST_RD_CLEARS_SRDY: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_rd && !set_srdy) |=> !st_srdy); // R9
   AST_RD_CLEARS_BFREE: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_rd && !set_bfree) |=> !st_bfree); // R9
endmodule

// File: rtl/rx_task_seq.sv
module rx_task_seq
   import rx_task_pkg::*;
#(
   parameter int unsigned SYM_W         = 2,
   parameter int unsigned BYTE_W        = 8,
   parameter int unsigned BLK_SYMS      = 69,
   parameter int unsigned S_IDX0        = 22,
   parameter int unsigned S_IDX1        = 45,
   parameter int unsigned S_IDX2        = 68,
   parameter int unsigned SID_SYMS      = 24,
   parameter int unsigned HDR_BYTES     = 12,
   parameter int unsigned BLK_BYTES     = 12,
   parameter int unsigned SID_BYTES     = 3,
   parameter bit          RAW_MSB_FIRST = 1'b1,
   localparam int unsigned RAW_SYMS  = BYTE_W / SYM_W,
   localparam int unsigned MAX_SYMS  = max2(max2(BLK_SYMS, SID_SYMS), RAW_SYMS),
   localparam int unsigned IDX_W     = $clog2(MAX_SYMS),
   localparam int unsigned MAX_BYTES = max2(max2(HDR_BYTES, BLK_BYTES), SID_BYTES),
   localparam int unsigned BUF_AW    = $clog2(MAX_BYTES),
   localparam int unsigned CNT_W     = $clog2(MAX_BYTES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [1:0]        cmd_code,
   input  logic              sym_irq_en,
   input  logic              sym_valid,
   input  logic [SYM_W-1:0]  sym_data,
   output logic              pay_valid,
   output logic [SYM_W-1:0]  pay_data,
   input  logic              dec_valid,
   input  logic [BYTE_W-1:0] dec_byte,
   input  logic              dec_crc_ok,
   output logic              dec_ready,
   output logic              buf_we,
   output logic [BUF_AW-1:0] buf_addr,
   output logic [BYTE_W-1:0] buf_wdata,
   input  logic              stat_rd,
   input  logic              buf_rd,
   output logic              st_bfree,
   output logic              st_irq,
   output logic              st_srdy,
   output logic [SYM_W-1:0]  st_sval,
   output logic              st_crcerr,
   output logic              busy
);
   if (BYTE_W % SYM_W != 0 || RAW_SYMS < 2) begin : g_bad_width
      $error("byte width must hold a whole number of at least two symbols");
   end
   if (!(S_IDX0 < S_IDX1 && S_IDX1 < S_IDX2 && S_IDX2 == BLK_SYMS - 1)) begin : g_bad_spos
      $error("status positions must rise and the last must close the block");
   end
   if (SID_SYMS < 2 || MAX_BYTES < 2) begin : g_bad_len
      $error("station identity length or byte counts too small");
   end

   task_e            kind_q;
   logic             busy_q;
   logic             fin_pend;
   logic [SYM_W-1:0] sval_pend;

   logic [IDX_W-1:0]  idx;
   logic              is_s, is_final;
   logic              is_dec;
   logic              sym_acc;
   logic              s_mid, fin_now;
   logic              complete_dec, complete_raw;
   logic [SYM_W-1:0]  fin_sval;
   logic [CNT_W-1:0]  expected;
   logic              col_active, acc_byte, last_now, bytes_done, crc_ok_eff;
   logic [BUF_AW-1:0] col_addr;
   logic [BYTE_W-1:0] col_data;
   logic [BYTE_W-1:0] raw_byte;

   assign is_dec  = (kind_q != TK_RAW);
   assign sym_acc = sym_valid && busy_q && !fin_pend && !cmd_wr;
   assign s_mid   = sym_acc && is_dec && is_s && !is_final;
   assign fin_now = sym_acc && is_final;

   always_comb begin
      unique case (kind_q)
         TK_HDR:  expected = CNT_W'(HDR_BYTES);
         TK_BLK:  expected = CNT_W'(BLK_BYTES);
         default: expected = CNT_W'(SID_BYTES);
      endcase
   end

   assign col_active   = busy_q && is_dec && !cmd_wr;
   assign complete_dec = col_active && (fin_now || fin_pend) && (bytes_done || last_now);
   assign complete_raw = fin_now && !is_dec;
   assign fin_sval     = fin_now ? sym_data : sval_pend;

   rx_sym_track #(
      .IDX_W(IDX_W), .BLK_SYMS(BLK_SYMS), .S_IDX0(S_IDX0), .S_IDX1(S_IDX1),
      .S_IDX2(S_IDX2), .SID_SYMS(SID_SYMS), .RAW_SYMS(RAW_SYMS)
   ) track_i (
      .clk(clk), .rst_n(rst_n), .restart(cmd_wr), .advance(sym_acc),
      .kind(kind_q), .idx(idx), .is_s(is_s), .is_final(is_final)
   );

   rx_raw_pack #(
      .SYM_W(SYM_W), .BYTE_W(BYTE_W), .MSB_FIRST(RAW_MSB_FIRST)
   ) pack_i (
      .clk(clk), .rst_n(rst_n), .clear(cmd_wr),
      .shift_en(sym_acc && !is_dec), .sym(sym_data), .byte_next(raw_byte)
   );

   rx_byte_collect #(
      .BYTE_W(BYTE_W), .CNT_W(CNT_W), .AW(BUF_AW)
   ) coll_i (
      .clk(clk), .rst_n(rst_n), .clear(cmd_wr), .active(col_active),
      .expected(expected), .dec_valid(dec_valid), .dec_byte(dec_byte),
      .dec_crc_ok(dec_crc_ok), .dec_ready(dec_ready), .accept(acc_byte),
      .last_now(last_now), .done(bytes_done), .crc_ok_eff(crc_ok_eff),
      .waddr(col_addr), .wdata(col_data)
   );

   rx_status_regs #(.SYM_W(SYM_W)) stat_i (
      .clk(clk), .rst_n(rst_n),
      .set_srdy(s_mid || complete_dec),
      .set_irq((s_mid && sym_irq_en) || complete_dec || complete_raw),
      .set_bfree(complete_dec || complete_raw),
      .ld_sval(s_mid || complete_dec),
      .sval_in(s_mid ? sym_data : fin_sval),
      .ld_crc(complete_dec), .crcerr_in(!crc_ok_eff),
      .stat_rd(stat_rd), .buf_rd(buf_rd),
      .st_bfree(st_bfree), .st_irq(st_irq), .st_srdy(st_srdy),
      .st_sval(st_sval), .st_crcerr(st_crcerr)
   );

   assign pay_valid = sym_acc && is_dec && !is_s;
   assign pay_data  = sym_data;

   assign buf_we    = acc_byte || complete_raw;
   assign buf_addr  = complete_raw ? '0 : col_addr;
   assign buf_wdata = complete_raw ? raw_byte : col_data;
   assign busy      = busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         kind_q    <= TK_HDR;
         busy_q    <= 1'b0;
         fin_pend  <= 1'b0;
         sval_pend <= '0;
      end else if (cmd_wr) begin
         kind_q   <= task_e'(cmd_code);
         busy_q   <= 1'b1;
         fin_pend <= 1'b0;
      end else if (complete_dec || complete_raw) begin
         busy_q   <= 1'b0;
         fin_pend <= 1'b0;
      end else if (fin_now) begin
         fin_pend  <= 1'b1;
         sval_pend <= sym_data;
      end
   end

   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (s_mid && !sym_irq_en && !st_irq) |=> !st_irq); // R3
   AST_FINAL_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
      complete_dec |=> (st_bfree && st_srdy && st_irq && !busy)); // R4
   AST_RAW_NO_PAY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && kind_q == TK_RAW) |-> !pay_valid); // R6
   AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_wr |=> (busy && idx == '0)); // R8
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> (!pay_valid && !dec_ready && !buf_we)); // R10
endmodule

// File: tb/rx_task_seq_tb.sv
module rx_task_seq_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_wr = 1'b0;
   logic [1:0] cmd_code = 2'd0;
   logic       sym_irq_en = 1'b0;
   logic       sym_valid = 1'b0;
   logic [1:0] sym_data = 2'd0;
   logic       pay_valid;
   logic [1:0] pay_data;
   logic       dec_valid = 1'b0;
   logic [7:0] dec_byte = 8'd0;
   logic       dec_crc_ok = 1'b0;
   logic       dec_ready;
   logic       buf_we;
   logic [3:0] buf_addr;
   logic [7:0] buf_wdata;
   logic       stat_rd = 1'b0;
   logic       buf_rd = 1'b0;
   logic       st_bfree, st_irq, st_srdy, st_crcerr, busy;
   logic [1:0] st_sval;

   int checks = 0;
   int errors = 0;
   int pay_cnt = 0;
   logic [1:0] paym [0:1023];
   logic [7:0] bufm [0:15];

   always #2 clk = ~clk;

   rx_task_seq dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
      .sym_irq_en(sym_irq_en), .sym_valid(sym_valid), .sym_data(sym_data),
      .pay_valid(pay_valid), .pay_data(pay_data), .dec_valid(dec_valid),
      .dec_byte(dec_byte), .dec_crc_ok(dec_crc_ok), .dec_ready(dec_ready),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
      .stat_rd(stat_rd), .buf_rd(buf_rd), .st_bfree(st_bfree), .st_irq(st_irq),
      .st_srdy(st_srdy), .st_sval(st_sval), .st_crcerr(st_crcerr), .busy(busy)
   );

   always @(posedge clk) begin
      if (buf_we) bufm[buf_addr] <= buf_wdata;
      if (pay_valid) begin
         paym[pay_cnt] <= pay_data;
         pay_cnt <= pay_cnt + 1;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cmd(input logic [1:0] c);
      @(negedge clk); cmd_wr = 1'b1; cmd_code = c;
      @(posedge clk); #1 cmd_wr = 1'b0;
   endtask

   task automatic sym(input logic [1:0] v);
      @(negedge clk); sym_valid = 1'b1; sym_data = v;
      @(posedge clk); #1 sym_valid = 1'b0;
   endtask

   task automatic dec(input logic [7:0] b, input logic ok);
      @(negedge clk); dec_valid = 1'b1; dec_byte = b; dec_crc_ok = ok;
      @(posedge clk); #1 dec_valid = 1'b0;
   endtask

   task automatic strd();
      @(negedge clk); stat_rd = 1'b1;
      @(posedge clk); #1 stat_rd = 1'b0;
   endtask

   task automatic brd();
      @(negedge clk); buf_rd = 1'b1;
      @(posedge clk); #1 buf_rd = 1'b0;
   endtask

   function automatic logic [1:0] pat(input int k, input int i);
      return 2'((i * 3 + k + i / 7) % 4);
   endfunction

   function automatic logic [7:0] bval(input int k, input int j);
      return 8'((k * 37 + j * 11 + 5) % 256);
   endfunction

   // Runs one 69-symbol block; nb bytes delivered before the final status symbol.
   task automatic run_block(input logic [1:0] code, input int k, input bit irq_en,
                            input int nb, input logic crc_ok);
      int base;
      int pi;
      sym_irq_en = irq_en;
      strd(); brd();
      base = pay_cnt;
      cmd(code);
      for (int i = 0; i < 68; i++) begin
         sym(pat(k, i));
         if (i == 22 || i == 45) begin
            chk(st_srdy == 1'b1, "R3 srdy on status symbol", st_srdy, 1);
            chk(st_sval == pat(k, i), "R3 sval value", st_sval, pat(k, i));
            chk(st_irq == irq_en, "R3 irq gated by enable", st_irq, irq_en);
            chk(st_bfree == 1'b0, "R4 no bfree mid block", st_bfree, 0);
            strd();
            chk(st_srdy == 1'b0 && st_irq == 1'b0, "R9 status read clears",
                {st_srdy, st_irq}, 0);
         end
         if (i == 50) for (int j = 0; j < nb; j++) dec(bval(k, j), (j == 11) ? crc_ok : 1'b0);
      end
      if (nb == 12) chk(dec_ready == 1'b0, "R2 ready low after 12 bytes", dec_ready, 0);
      sym(pat(k, 68));
      if (nb < 12) begin
         chk(st_bfree == 1'b0 && st_srdy == 1'b0, "R4 final symbol deferred",
             {st_bfree, st_srdy}, 0);
         chk(busy == 1'b1, "R4 still busy while bytes owed", busy, 1);
         for (int j = nb; j < 12; j++) dec(bval(k, j), (j == 11) ? crc_ok : 1'b0);
      end
      chk(st_bfree && st_srdy && st_irq, "R4 completion flags together",
          {st_bfree, st_srdy, st_irq}, 7);
      chk(st_sval == pat(k, 68), "R4 final sval", st_sval, pat(k, 68));
      chk(busy == 1'b0, "R4 busy falls", busy, 0);
      chk(st_crcerr == !crc_ok, "R5 crcerr from checksum", st_crcerr, !crc_ok);
      chk(pay_cnt - base == 66, "R1 payload count", pay_cnt - base, 66);
      pi = base;
      for (int i = 0; i < 69; i++) begin
         if (i != 22 && i != 45 && i != 68) begin
            chk(paym[pi] == pat(k, i), "R1 payload order", paym[pi], pat(k, i));
            pi++;
         end
      end
      for (int j = 0; j < 12; j++)
         chk(bufm[j] == bval(k, j), "R2 buffer byte", bufm[j], bval(k, j));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int base;
      logic [1:0] fs, fl, fv;
      logic       fb;
      repeat (3) @(posedge clk);
      #1;
      chk({st_bfree, st_irq, st_srdy, st_crcerr, busy} == 5'd0, "R11 reset flags",
          {st_bfree, st_irq, st_srdy, st_crcerr, busy}, 0);
      chk(st_sval == 2'd0, "R11 reset sval", st_sval, 0);
      rst_n = 1'b1;
      @(posedge clk); #1;

      // Blocks over all status values, both enable settings, early and late bytes.
      for (int k = 0; k < 4; k++) begin
         run_block(2'(k % 2), k, k[0], (k < 2) ? 5 : 12, k[1]);
      end

      // Raw sweep over every byte value.
      strd();
      for (int b = 0; b < 256; b++) begin
         base = pay_cnt;
         fs = st_sval; fv = st_srdy; fb = st_crcerr;
         cmd(2'd2);
         for (int s = 3; s >= 0; s--) sym(2'((b >> (2 * s)) & 3));
         chk(bufm[0] == 8'(b), "R6 raw byte packing", bufm[0], b);
         chk(st_bfree && st_irq && !busy, "R6 raw completion", {st_bfree, st_irq, busy}, 6);
         chk(st_srdy == fv && st_sval == fs && st_crcerr == fb, "R6 raw leaves status",
             {st_srdy, st_sval, st_crcerr}, {fv, fs, fb});
         chk(pay_cnt == base, "R6 raw forwards nothing", pay_cnt - base, 0);
         strd(); brd();
         chk(st_bfree == 1'b0, "R9 buffer read clears bfree", st_bfree, 0);
      end

      // Station identity: failing then passing checksum.
      for (int r = 0; r < 2; r++) begin
         base = pay_cnt;
         strd(); brd();
         cmd(2'd3);
         for (int i = 0; i < 23; i++) sym(pat(r + 5, i));
         for (int j = 0; j < 3; j++) dec(bval(r + 9, j), (j == 2) ? r[0] : 1'b0);
         chk(st_bfree == 1'b0, "R7 waits for final symbol", st_bfree, 0);
         sym(2'd2 + 2'(r));
         chk(st_bfree && st_srdy && st_irq, "R7 station id completion",
             {st_bfree, st_srdy, st_irq}, 7);
         chk(st_sval == 2'd2 + 2'(r), "R7 station id sval", st_sval, 2 + r);
         chk(st_crcerr == !r[0], "R5 station id crcerr", st_crcerr, !r[0]);
         chk(pay_cnt - base == 23, "R7 station id payload", pay_cnt - base, 23);
         for (int j = 0; j < 3; j++)
            chk(bufm[j] == bval(r + 9, j), "R7 station id bytes", bufm[j], bval(r + 9, j));
      end

      // Abort: header cut short by a block task; status index restarts.
      strd(); brd();
      sym_irq_en = 1'b0;
      cmd(2'd0);
      for (int i = 0; i < 15; i++) sym(2'd1);
      cmd(2'd1);
      for (int i = 0; i < 22; i++) sym(2'd0);
      chk(st_srdy == 1'b0, "R8 no status before restarted index 22", st_srdy, 0);
      sym(2'd3);
      chk(st_srdy == 1'b1 && st_sval == 2'd3, "R8 status at restarted index 22",
          {st_srdy, st_sval}, 7);
      cmd(2'd2);
      sym(2'd2); sym(2'd2); sym(2'd1); sym(2'd1);
      chk(bufm[0] == 8'hA5, "R8 raw after abort", bufm[0], 8'hA5);
      chk(busy == 1'b0, "R8 idle after aborted chain", busy, 0);

      // Idle: symbols and bytes ignored.
      strd(); brd();
      base = pay_cnt;
      fl = st_sval;
      for (int i = 0; i < 5; i++) sym(2'd3);
      chk(dec_ready == 1'b0, "R10 ready low when idle", dec_ready, 0);
      dec(8'h3C, 1'b0);
      chk(pay_cnt == base, "R10 no payload when idle", pay_cnt - base, 0);
      chk({st_bfree, st_irq, st_srdy} == 3'd0 && st_sval == fl, "R10 flags untouched",
          {st_bfree, st_irq, st_srdy, st_sval}, {3'd0, fl});

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule